// File: doc/BRIEF.md
# Bayer Camera Capture with Greyscale Decimation

This block sits on the pixel-clock side of a camera input. It accepts a continuous raster of Bayer-mosaic frames, one 8-bit sample per clock while the line-valid input is high. Each output pixel is the mean of one 2x2 mosaic cell (one red, two green, one blue sample). A subset of these cells is kept, so the stored picture has one of two sizes. A single control bit chooses between full output size (default 200x160) and half output size (100x80). The bit is sampled only when a frame begins.

The results go into an external dual-bank frame store through a registered write port. The bank bit is the top address bit. One bank collects the frame being captured. The other bank holds the last completed frame for a consumer. The consumer reads through a pass-through read port, and the block fills in the bank bit of that port. The banks swap on the rising edge of frame sync. A ready flag and the size of the held frame are reported alongside.

Top module: `grey_cap`

## Requirements
- R1: During and right after reset, `frm_ready` is 0 and `fb_we` is 0.
- R2: Each stored value is (a + b + c + d) >> 2, truncated. Here a, b are two horizontally adjacent samples at an even column 2i and column 2i+1 of an even row 2j, and c, d are the samples at the same columns of row 2j+1.
- R3: In full mode (control bit 0), a frame yields OW x OH stored pixels. Pixel (x, y) is taken from cell (floor(x*QW/OW), floor(y*QH/OH)), where QW, QH are half the source width and height.
- R4: In half mode (control bit 1), the same rule applies with OW/2 and OH/2 in place of OW and OH.
- R5: Pixel (x, y) is written at low address y*W + x, where W is the active output width. The top address bit is the bank, and no low address reaches W*H.
- R6: The first frame sync after reset does not raise `frm_ready`. Every later rising edge of frame sync hands the bank just filled to the reader and sets `frm_ready`. The flag then stays 1. Frame k after reset (counting from 0) lands in bank k mod 2.
- R7: While `frm_ready` is 1, no write goes to the bank held for the reader.
- R8: The control bit is latched at frame sync. A change in mid-frame does not alter the current frame. `frm_half` reports the mode of the held frame and changes only on frame sync.
- R9: `fb_raddr` is `rd_addr` with the held bank as its top bit.
- R10: Writes occur only in the cycle after an in-line sample, and never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| cam_vsync | input | 1 | Frame sync; its rising edge starts a frame |
| cam_href | input | 1 | Line valid; one sample per clock while high |
| cam_pix | input | 8 | Bayer sample |
| cfg_half | input | 1 | Output size select: 0 full, 1 half |
| rd_addr | input | ADDR_W | Reader pixel address within the held frame |
| fb_we | output | 1 | Frame store write enable |
| fb_waddr | output | ADDR_W+1 | Write address, bank in the top bit |
| fb_wdata | output | 8 | Grey value to store |
| fb_raddr | output | ADDR_W+1 | Read address to the frame store, held bank on top |
| frm_ready | output | 1 | A completed frame is held for reading |
| frm_half | output | 1 | Size mode of the held frame |

## Verification
A wrong horizontal or vertical step accumulator changes the number of writes in a frame and moves values into the wrong cells. Both show up as soon as the completed frame is read back after the next frame sync. A corrupted line-buffer entry or pair register gives a wrong grey value at the matching address of that same frame. A bad bank or mode register is visible within one frame sync: `fb_raddr`'s top bit alternates wrongly, writes hit the held bank, or `frm_half` reports the wrong size.

// File: rtl/grey_cap_pkg.sv
package grey_cap_pkg;

   localparam int PIX_W = 8;

   typedef logic [PIX_W-1:0] pix_t;
   typedef logic [PIX_W:0]   pair_t;

   // mean of two horizontal pair sums, truncated
   function automatic pix_t cell_mean(pair_t upper, pair_t lower);
      logic [PIX_W+1:0] total;
      total = {1'b0, upper} + {1'b0, lower};
      return total[PIX_W+1:2];
   endfunction

endpackage

// File: rtl/grey_cap_timing.sv
module grey_cap_timing (
   input  logic clk,
   input  logic rst_n,
   input  logic vsync,
   input  logic href,
   output logic frame_start,
   output logic line_end,
   output logic col_odd,
   output logic row_odd
);

   logic vs_q;
   logic hr_q;

   assign frame_start = vsync & ~vs_q;
   assign line_end    = hr_q & ~href;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q    <= 1'b0;
         hr_q    <= 1'b0;
         col_odd <= 1'b0;
         row_odd <= 1'b0;
      end else begin
         vs_q <= vsync;
         hr_q <= href;
         if (href) col_odd <= ~col_odd;
         else      col_odd <= 1'b0;
         if (frame_start)   row_odd <= 1'b0;
         else if (line_end) row_odd <= ~row_odd;
      end
   end

endmodule

// File: rtl/grey_cap_axis.sv
module grey_cap_axis #(
   parameter int QN    = 320,
   parameter int N_HI  = 200,
   parameter int IDX_W = $clog2(N_HI + 1),
   parameter int ACC_W = $clog2(QN * N_HI + N_HI + 1) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic             half,
   output logic             sel,
   output logic [IDX_W-1:0] idx
);

   localparam logic [ACC_W-1:0] QN_V   = ACC_W'(QN);
   localparam logic [ACC_W-1:0] FULL_V = ACC_W'(N_HI);
   localparam logic [ACC_W-1:0] HALF_V = ACC_W'(N_HI / 2);

   logic [ACC_W-1:0] nmax;
   logic [ACC_W-1:0] target;
   logic [ACC_W-1:0] cell_pos;

   assign nmax = half ? HALF_V : FULL_V;
   assign sel  = (ACC_W'(idx) < nmax) && (target < cell_pos + nmax);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target   <= '0;
         cell_pos <= '0;
         idx      <= '0;
      end else if (clr) begin
         target   <= '0;
         cell_pos <= '0;
         idx      <= '0;
      end else if (step) begin
         cell_pos <= cell_pos + nmax;
         if (sel) begin
            target <= target + QN_V;
            idx    <= idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/grey_cap_cell.sv
module grey_cap_cell
   import grey_cap_pkg::*;
#(
   parameter int OW_HI = 200,
   parameter int XI_W  = $clog2(OW_HI + 1)
) (
   input  logic            clk,
   input  pix_t            pix,
   input  logic            valid,
   input  logic            col_odd,
   input  logic            row_odd,
   input  logic            hsel,
   input  logic            vsel,
   input  logic [XI_W-1:0] xi,
   output logic            wr_req,
   output pix_t            grey
);

   pix_t  held;
   pair_t pair_sum;
   pair_t upper [OW_HI];
   logic  keep;

   assign pair_sum = {1'b0, held} + {1'b0, pix};
   assign keep     = valid & col_odd & hsel & vsel;
   assign wr_req   = keep & row_odd;
   assign grey     = cell_mean(upper[xi], pair_sum);

   always_ff @(posedge clk) begin
      if (valid && !col_odd) held <= pix;
      if (keep && !row_odd)  upper[xi] <= pair_sum;
   end

endmodule

// File: rtl/grey_cap.sv
module grey_cap
   import grey_cap_pkg::*;
#(
   parameter int SRC_W = 640,
   parameter int SRC_H = 480,
   parameter int OW_HI = 200,
   parameter int OH_HI = 160,
   parameter int ADDR_W = $clog2(OW_HI * OH_HI)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cam_vsync,
   input  logic              cam_href,
   input  logic [7:0]        cam_pix,
   input  logic              cfg_half,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              fb_we,
   output logic [ADDR_W:0]   fb_waddr,
   output logic [7:0]        fb_wdata,
   output logic [ADDR_W:0]   fb_raddr,
   output logic              frm_ready,
   output logic              frm_half
);

   localparam int QW     = SRC_W / 2;
   localparam int QH     = SRC_H / 2;
   localparam int XI_W   = $clog2(OW_HI + 1);
   localparam int YI_W   = $clog2(OH_HI + 1);
   localparam int XACC_W = $clog2(QW * OW_HI + OW_HI + 1) + 1;
   localparam int YACC_W = $clog2(QH * OH_HI + OH_HI + 1) + 1;
   localparam logic [ADDR_W-1:0] ROW_FULL = ADDR_W'(OW_HI);
   localparam logic [ADDR_W-1:0] ROW_HALF = ADDR_W'(OW_HI / 2);

   // elaboration-time parameter checks
   if (SRC_W % 2 != 0 || SRC_H % 2 != 0) begin : g_bad_src
      $error("grey_cap: source size must be even in both axes");
   end
   if (OW_HI % 2 != 0 || OH_HI % 2 != 0) begin : g_bad_out
      $error("grey_cap: full output size must be even in both axes");
   end
   if (OW_HI > QW || OH_HI > QH) begin : g_bad_ratio
      $error("grey_cap: output may not exceed the mosaic cell grid");
   end
   if (ADDR_W < $clog2(OW_HI * OH_HI)) begin : g_bad_addr
      $error("grey_cap: address too narrow for one bank");
   end

   logic              frame_start;
   logic              line_end;
   logic              col_odd;
   logic              row_odd;
   logic              hsel;
   logic              vsel;
   logic [XI_W-1:0]   xi;
   logic [YI_W-1:0]   yi;
   logic              wr_req;
   pix_t              grey;

   logic              cur_half;
   logic              started;
   logic              wr_bank;
   logic              rd_bank;
   logic [ADDR_W-1:0] row_base;

   grey_cap_timing u_timing (
      .clk         (clk),
      .rst_n       (rst_n),
      .vsync       (cam_vsync),
      .href        (cam_href),
      .frame_start (frame_start),
      .line_end    (line_end),
      .col_odd     (col_odd),
      .row_odd     (row_odd)
   );

   grey_cap_axis #(
      .QN    (QW),
      .N_HI  (OW_HI),
      .IDX_W (XI_W),
      .ACC_W (XACC_W)
   ) u_xaxis (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (~cam_href),
      .step  (cam_href & col_odd),
      .half  (cur_half),
      .sel   (hsel),
      .idx   (xi)
   );

   grey_cap_axis #(
      .QN    (QH),
      .N_HI  (OH_HI),
      .IDX_W (YI_W),
      .ACC_W (YACC_W)
   ) u_yaxis (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (frame_start),
      .step  (line_end & row_odd),
      .half  (cur_half),
      .sel   (vsel),
      .idx   (yi)
   );

   grey_cap_cell #(
      .OW_HI (OW_HI),
      .XI_W  (XI_W)
   ) u_cell (
      .clk     (clk),
      .pix     (cam_pix),
      .valid   (cam_href),
      .col_odd (col_odd),
      .row_odd (row_odd),
      .hsel    (hsel),
      .vsel    (vsel),
      .xi      (xi),
      .wr_req  (wr_req),
      .grey    (grey)
   );

   // bank and mode bookkeeping at frame boundaries
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_half  <= 1'b0;
         started   <= 1'b0;
         wr_bank   <= 1'b0;
         rd_bank   <= 1'b0;
         frm_ready <= 1'b0;
         frm_half  <= 1'b0;
         row_base  <= '0;
      end else if (frame_start) begin
         cur_half <= cfg_half;
         started  <= 1'b1;
         row_base <= '0;
         if (started) begin
            rd_bank   <= wr_bank;
            wr_bank   <= ~wr_bank;
            frm_ready <= 1'b1;
            frm_half  <= cur_half;
         end
      end else if (line_end && row_odd && vsel) begin
         row_base <= row_base + (cur_half ? ROW_HALF : ROW_FULL);
      end
   end

   // registered write port
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fb_we    <= 1'b0;
         fb_waddr <= '0;
         fb_wdata <= '0;
      end else begin
         fb_we    <= wr_req;
         fb_waddr <= {wr_bank, row_base + ADDR_W'(xi)};
         fb_wdata <= grey;
      end
   end

   assign fb_raddr = {rd_bank, rd_addr};

   logic unused_yi;
   assign unused_yi = ^yi;

endmodule

// File: rtl/grey_cap_chk.sv
module grey_cap_chk #(
   parameter int ADDR_W = 15,
   parameter int OW_HI  = 200,
   parameter int OH_HI  = 160
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cam_vsync,
   input logic            cam_href,
   input logic            fb_we,
   input logic [ADDR_W:0] fb_waddr,
   input logic [ADDR_W:0] fb_raddr,
   input logic            frm_ready,
   input logic            frm_half,
   input logic            cur_half
);

   localparam int LIM_FULL = OW_HI * OH_HI;
   localparam int LIM_HALF = (OW_HI / 2) * (OH_HI / 2);

   AST_WR_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      fb_we |-> $past(cam_href)); // R10

   AST_WR_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      fb_we |=> !fb_we); // R10

   AST_WR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      fb_we |-> (int'(fb_waddr[ADDR_W-1:0]) < (cur_half ? LIM_HALF : LIM_FULL))); // R5

   AST_BANK_APART: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_we && frm_ready) |-> (fb_waddr[ADDR_W] != fb_raddr[ADDR_W])); // R7

   AST_HALF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cam_vsync) |-> $stable(frm_half)); // R8

   AST_READY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      frm_ready |=> frm_ready); // R6

endmodule

bind grey_cap grey_cap_chk #(
   .ADDR_W (ADDR_W),
   .OW_HI  (OW_HI),
   .OH_HI  (OH_HI)
) i_grey_cap_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cam_vsync (cam_vsync),
   .cam_href  (cam_href),
   .fb_we     (fb_we),
   .fb_waddr  (fb_waddr),
   .fb_raddr  (fb_raddr),
   .frm_ready (frm_ready),
   .frm_half  (frm_half),
   .cur_half  (cur_half)
);

// File: tb/test_grey_cap.sv
module test_grey_cap;

   localparam int CLK_P = 10;
   localparam int SW    = 32;
   localparam int SH    = 16;
   localparam int OWH   = 8;
   localparam int OHH   = 6;
   localparam int QWB   = SW / 2;
   localparam int QHB   = SH / 2;
   localparam int AW    = $clog2(OWH * OHH);
   localparam int NVEC  = 4;

   // vector: {half at frame sync, half written mid-frame, seed}
   localparam logic [9:0] VEC [NVEC] = '{
      {1'b0, 1'b1, 8'd3},
      {1'b1, 1'b0, 8'd5},
      {1'b0, 1'b0, 8'd9},
      {1'b1, 1'b1, 8'd12}
   };

   logic          clk;
   logic          rst_n;
   logic          cam_vsync;
   logic          cam_href;
   logic [7:0]    cam_pix;
   logic          cfg_half;
   logic [AW-1:0] rd_addr;
   logic          fb_we;
   logic [AW:0]   fb_waddr;
   logic [7:0]    fb_wdata;
   logic [AW:0]   fb_raddr;
   logic          frm_ready;
   logic          frm_half;

   int checks = 0;
   int errs   = 0;
   int wr_cnt = 0;
   int line_bad = 0;
   int spaced_bad = 0;
   int bank_bad = 0;
   logic href_q = 1'b0;
   logic we_q = 1'b0;
   logic [7:0] mem [2**(AW+1)];

   grey_cap #(
      .SRC_W (SW),
      .SRC_H (SH),
      .OW_HI (OWH),
      .OH_HI (OHH)
   ) i_grey_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cam_vsync (cam_vsync),
      .cam_href  (cam_href),
      .cam_pix   (cam_pix),
      .cfg_half  (cfg_half),
      .rd_addr   (rd_addr),
      .fb_we     (fb_we),
      .fb_waddr  (fb_waddr),
      .fb_wdata  (fb_wdata),
      .fb_raddr  (fb_raddr),
      .frm_ready (frm_ready),
      .frm_half  (frm_half)
   );

   initial begin
      clk = 1'b0;
      forever #(CLK_P / 2) clk = ~clk;
   end

   // frame store model and port monitors
   always @(posedge clk) begin
      if (fb_we) begin
         mem[fb_waddr] <= fb_wdata;
         wr_cnt <= wr_cnt + 1;
         if (!href_q) line_bad <= line_bad + 1;                        // R10
         if (we_q) spaced_bad <= spaced_bad + 1;                       // R10
         if (frm_ready && fb_waddr[AW] == fb_raddr[AW]) bank_bad <= bank_bad + 1; // R7
      end
      href_q <= cam_href;
      we_q   <= fb_we;
   end

   function automatic logic [7:0] pix_at(int seed, int r, int c);
      return 8'(r * 29 + c * 13 + seed * 7 + r * c);
   endfunction

   function automatic int exp_grey(int seed, bit half, int x, int y);
      int ow = half ? OWH / 2 : OWH;
      int oh = half ? OHH / 2 : OHH;
      int qx = (x * QWB) / ow;
      int qy = (y * QHB) / oh;
      int s  = pix_at(seed, 2*qy, 2*qx) + pix_at(seed, 2*qy, 2*qx+1)
             + pix_at(seed, 2*qy+1, 2*qx) + pix_at(seed, 2*qy+1, 2*qx+1);
      return s >> 2;
   endfunction

   task automatic chk(string req, int act, int expv);
      checks++;
      if (act != expv) begin
         errs++;
         $display("FAIL %s actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic sync_pulse();
      @(negedge clk) cam_vsync = 1'b1;
      @(negedge clk);
      @(negedge clk) cam_vsync = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_frame(int seed, bit mid_half);
      for (int r = 0; r < SH; r++) begin
         if (r == SH / 2) cfg_half = mid_half;
         for (int c = 0; c < SW; c++) begin
            @(negedge clk);
            cam_href = 1'b1;
            cam_pix  = pix_at(seed, r, c);
         end
         @(negedge clk) cam_href = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic verify(int fi, int seed, bit half, int writes);
      int ow = half ? OWH / 2 : OWH;
      int oh = half ? OHH / 2 : OHH;
      chk("R6 ready after completed frame", int'(frm_ready), 1);
      chk("R6 held bank parity", int'(fb_raddr[AW]), fi % 2);
      chk("R8 held frame mode", int'(frm_half), int'(half));
      chk("R3 R4 writes per frame", writes, ow * oh);
      for (int y = 0; y < oh; y++) begin
         for (int x = 0; x < ow; x++) begin
            rd_addr = AW'(y * ow + x);
            #1;
            chk("R2 R5 R9 stored pixel", int'(mem[fb_raddr]), exp_grey(seed, half, x, y));
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      int base_cnt;
      rst_n     = 1'b0;
      cam_vsync = 1'b0;
      cam_href  = 1'b0;
      cam_pix   = '0;
      cfg_half  = 1'b0;
      rd_addr   = '0;
      repeat (3) @(negedge clk);
      chk("R1 ready in reset", int'(frm_ready), 0);
      chk("R1 write in reset", int'(fb_we), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", int'(frm_ready), 0);

      base_cnt = 0;
      for (int i = 0; i <= NVEC; i++) begin
         if (i < NVEC) cfg_half = VEC[i][9];
         sync_pulse();
         if (i == 0) begin
            chk("R6 first sync no ready", int'(frm_ready), 0);
         end else begin
            verify(i - 1, int'(VEC[i-1][7:0]), VEC[i-1][9], wr_cnt - base_cnt);
            base_cnt = wr_cnt;
         end
         if (i < NVEC) send_frame(int'(VEC[i][7:0]), VEC[i][8]);
      end

      // directed corner checks
      chk("R10 writes outside line", line_bad, 0);
      chk("R10 back-to-back writes", spaced_bad, 0);
      chk("R7 writes into held bank", bank_bad, 0);

      // mid-frame reset clears the ready state
      cfg_half = 1'b0;
      sync_pulse();
      send_frame(1, 1'b0);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      chk("R1 ready cleared by reset", int'(frm_ready), 0);
      chk("R1 no write in reset", int'(fb_we), 0);
      rst_n = 1'b1;
      sync_pulse();
      chk("R6 first sync after reset no ready", int'(frm_ready), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

endmodule